// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of an eight-input programmable interrupt controller. Software writes bytes at two offsets. The decoder turns those writes into three things. The first is a multi-step initialization sequence that sets up the controller. The second is a set of run-time operation commands. The third is direct loads of the interrupt mask. The configuration it holds is driven out as plain control outputs. That configuration is the trigger mode, single or cascade operation, the vector base, the cascade map and the automatic end-of-interrupt flag.

The interrupt core sits beside this block. It owns the request and in-service registers and feeds them in, so they can be read back and so that a non-specific end-of-interrupt can find its target line. An end-of-interrupt command reaches the core as a one-cycle strobe. The strobe carries a line number and a flag that tells specific from non-specific. Priority resolution and the acknowledge cycle belong to the core. Rotation, special-mask and buffering command bits are accepted and have no effect.

The register port is a simple strobe interface with no back-pressure. Every write is taken in the cycle it is presented. Read data is a combinational function of the offset and the current state. All the other pins are level control or status signals.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset the mask is 0, auto-EOI is off, the offset 0 readback shows the request register, and the sequencer is idle, so an offset 1 write loads the mask.
- R2: A write to offset 0 with bit 4 set starts initialization and clears the mask. It also latches the trigger mode from bit 3 (1 means edge) and selects cascade mode when bit 1 is 0. Bit 0 records whether a fourth word is wanted. When bit 0 is 0, auto-EOI is cleared; when it is 1, auto-EOI keeps its value.
- R3: The next offset 1 write is the second word. It sets the vector base to that byte with bits 2:0 forced to 0. In single mode it also clears the cascade map and ends initialization, whether or not a fourth word was requested.
- R4: In cascade mode, the offset 1 write after the second word is the third word. A master stores all 8 bits as the cascade map. A responder stores bits 2:0 with the upper bits 0. The sequencer then waits for a fourth word if one was requested, and otherwise goes idle.
- R5: The fourth word sets auto-EOI from its bit 1 and ends initialization.
- R6: An offset 1 write while the sequencer is idle loads the mask register. The mask does not change without a write.
- R7: An offset 0 write with bits 4:3 = 00 and bits 7:5 = 001 is a non-specific EOI. One cycle after the write, the decoder strobes `eoi_stb` with `eoi_specific` = 0 and `eoi_line` set to the highest set bit of the in-service input. If no in-service bit is set, there is no strobe.
- R8: An offset 0 write with bits 4:3 = 00 and bits 7:5 = 011 strobes a specific EOI one cycle later. `eoi_line` equals bits 2:0 of the byte and `eoi_specific` = 1.
- R9: Operation commands with bits 4:3 = 00 and any other value of bits 7:5 produce no strobe and change neither the mask nor the readback selection.
- R10: An offset 0 write with bits 4:3 = 01 and bit 1 set selects the readback: bit 0 = 1 selects the request register and bit 0 = 0 selects the in-service register. When bit 1 is clear, the selection is unchanged.
- R11: `rdata` follows `addr` in the same cycle. Offset 0 returns the selected status register and offset 1 returns the mask.
- R12: `eoi_stb` is high for exactly one cycle for each EOI command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| addr | input | 1 | Register offset (0 or 1) |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the current `addr` |
| req_in | input | NUM_LINES | Request register from the interrupt core |
| isr_in | input | NUM_LINES | In-service register from the interrupt core |
| edge_trig | output | 1 | 1 = edge triggered, 0 = level triggered |
| cascade_mode | output | 1 | 1 = cascade operation |
| vec_base | output | 8 | Vector base, low 3 bits zero |
| cascade_map | output | 8 | Responder map (master) or own ID (responder) |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| mask | output | NUM_LINES | Interrupt mask register |
| eoi_stb | output | 1 | One-cycle end-of-interrupt strobe |
| eoi_line | output | LINE_W | Line the EOI applies to |
| eoi_specific | output | 1 | 1 = specific EOI, 0 = non-specific |

## Verification
The bench builds two copies with NUM_LINES = 8. One copy is a master (IS_MASTER = 1) and the other is a responder (IS_MASTER = 0). Both copies see the same write stream, so one pass over all 256 third-word values checks both ways of storing the cascade map. With only eight lines, every in-service pattern for the non-specific EOI and every second-word byte for the vector base can be swept in full. The specific-EOI line numbers and all eight subcommand codes are also covered completely.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_W2   = 2'd1,
    SEQ_W3   = 2'd2,
    SEQ_W4   = 2'd3
  } seq_state_e;

  localparam logic [2:0] SUB_EOI_NONSPEC = 3'b001;
  localparam logic [2:0] SUB_EOI_SPEC    = 3'b011;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 addr,
  input  logic [BYTE_W-1:0]    wdata,
  output logic                 edge_trig,
  output logic                 cascade_mode,
  output logic [BYTE_W-1:0]    vec_base,
  output logic [BYTE_W-1:0]    cascade_map,
  output logic                 auto_eoi,
  output logic [NUM_LINES-1:0] mask
);
  localparam int LINE_W = $clog2(NUM_LINES);

  seq_state_e       state;
  logic             want_w4;
  logic [BYTE_W-1:0] map_next;

  // Third-word storage differs between master and responder builds
  generate
    if (IS_MASTER) begin : g_master
      assign map_next = wdata;
    end else begin : g_responder
      assign map_next = {{(BYTE_W-LINE_W){1'b0}}, wdata[LINE_W-1:0]};
    end
  endgenerate

  wire start_init = wr_en && !addr && wdata[4];
  wire data_wr    = wr_en && addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= SEQ_IDLE;
      want_w4      <= 1'b0;
      edge_trig    <= 1'b0;
      cascade_mode <= 1'b0;
      vec_base     <= '0;
      cascade_map  <= '0;
      auto_eoi     <= 1'b0;
      mask         <= '0;
    end else if (start_init) begin
      mask         <= '0;
      edge_trig    <= wdata[3];
      cascade_mode <= !wdata[1];
      want_w4      <= wdata[0];
      if (!wdata[0]) auto_eoi <= 1'b0;
      state        <= SEQ_W2;
    end else if (data_wr) begin
      unique case (state)
        SEQ_IDLE: mask <= wdata[NUM_LINES-1:0];
        SEQ_W2: begin
          vec_base <= {wdata[BYTE_W-1:LINE_W], {LINE_W{1'b0}}};
          if (cascade_mode) begin
            state <= SEQ_W3;
          end else begin
            cascade_map <= '0;
            state       <= SEQ_IDLE;
          end
        end
        SEQ_W3: begin
          cascade_map <= map_next;
          state       <= want_w4 ? SEQ_W4 : SEQ_IDLE;
        end
        SEQ_W4: begin
          auto_eoi <= wdata[1];
          state    <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pic_op_dec.sv
module pic_op_dec
  import pic_cmd_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 addr,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0] isr_in,
  output logic                 eoi_stb,
  output logic [LINE_W-1:0]    eoi_line,
  output logic                 eoi_specific,
  output logic                 sel_req
);
  logic [LINE_W-1:0] top_line;
  logic              isr_any;

  // Highest set in-service bit: later (higher) indices win
  always_comb begin
    top_line = '0;
    isr_any  = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (isr_in[i]) begin
        top_line = LINE_W'(i);
        isr_any  = 1'b1;
      end
    end
  end

  wire is_op   = wr_en && !addr && (wdata[4:3] == 2'b00);
  wire is_rsel = wr_en && !addr && (wdata[4:3] == 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoi_stb      <= 1'b0;
      eoi_line     <= '0;
      eoi_specific <= 1'b0;
      sel_req      <= 1'b1;
    end else begin
      eoi_stb <= 1'b0;
      if (is_op) begin
        if (wdata[7:5] == SUB_EOI_NONSPEC && isr_any) begin
          eoi_stb      <= 1'b1;
          eoi_line     <= top_line;
          eoi_specific <= 1'b0;
        end else if (wdata[7:5] == SUB_EOI_SPEC) begin
          eoi_stb      <= 1'b1;
          eoi_line     <= wdata[LINE_W-1:0];
          eoi_specific <= 1'b1;
        end
      end
      if (is_rsel && wdata[1]) sel_req <= wdata[0];
    end
  end
endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux
  import pic_cmd_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 addr,
  input  logic                 sel_req,
  input  logic [NUM_LINES-1:0] req_in,
  input  logic [NUM_LINES-1:0] isr_in,
  input  logic [NUM_LINES-1:0] mask,
  output logic [BYTE_W-1:0]    rdata
);
  always_comb begin
    rdata = '0;
    if (addr)         rdata[NUM_LINES-1:0] = mask;
    else if (sel_req) rdata[NUM_LINES-1:0] = req_in;
    else              rdata[NUM_LINES-1:0] = isr_in;
  end
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
  import pic_cmd_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter bit IS_MASTER = 1'b1,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 addr,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [BYTE_W-1:0]    rdata,
  input  logic [NUM_LINES-1:0] req_in,
  input  logic [NUM_LINES-1:0] isr_in,
  output logic                 edge_trig,
  output logic                 cascade_mode,
  output logic [BYTE_W-1:0]    vec_base,
  output logic [BYTE_W-1:0]    cascade_map,
  output logic                 auto_eoi,
  output logic [NUM_LINES-1:0] mask,
  output logic                 eoi_stb,
  output logic [LINE_W-1:0]    eoi_line,
  output logic                 eoi_specific
);
  logic sel_req;

  pic_init_seq #(.NUM_LINES(NUM_LINES), .IS_MASTER(IS_MASTER)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .edge_trig(edge_trig), .cascade_mode(cascade_mode), .vec_base(vec_base),
    .cascade_map(cascade_map), .auto_eoi(auto_eoi), .mask(mask)
  );

  pic_op_dec #(.NUM_LINES(NUM_LINES)) u_op (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .isr_in(isr_in), .eoi_stb(eoi_stb), .eoi_line(eoi_line),
    .eoi_specific(eoi_specific), .sel_req(sel_req)
  );

  pic_rd_mux #(.NUM_LINES(NUM_LINES)) u_rd (
    .addr(addr), .sel_req(sel_req), .req_in(req_in), .isr_in(isr_in),
    .mask(mask), .rdata(rdata)
  );
endmodule

// File: rtl/pic_cmd_decoder_chk.sv
module pic_cmd_decoder_chk #(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 addr,
  input logic [7:0]           wdata,
  input logic [NUM_LINES-1:0] isr_in,
  input logic                 auto_eoi,
  input logic [NUM_LINES-1:0] mask,
  input logic                 eoi_stb,
  input logic [LINE_W-1:0]    eoi_line,
  input logic                 eoi_specific
);
  localparam logic [NUM_LINES-1:0] ONE = {{(NUM_LINES-1){1'b0}}, 1'b1};

  p_init_clears_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (mask == '0));

  p_init_drops_aeoi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4] && !wdata[0]) |=> !auto_eoi);

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask));

  p_nonspec_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_stb && !eoi_specific) |-> (($past(isr_in) >> eoi_line) == ONE));

  p_spec_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_stb && eoi_specific) |-> (eoi_line == $past(wdata[LINE_W-1:0])));

  p_stb_from_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_stb |-> $past(wr_en && !addr && wdata[4:3] == 2'b00));
endmodule

bind pic_cmd_decoder pic_cmd_decoder_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .isr_in(isr_in), .auto_eoi(auto_eoi), .mask(mask), .eoi_stb(eoi_stb),
  .eoi_line(eoi_line), .eoi_specific(eoi_specific)
);

// File: tb/pic_cmd_decoder_test.sv
`timescale 1ns/1ps
module pic_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] req_in = 8'hA5;
  logic [7:0] isr_in = 8'h3C;

  logic [7:0] rdata, vec_base, cascade_map, mask;
  logic edge_trig, cascade_mode, auto_eoi, eoi_stb, eoi_specific;
  logic [2:0] eoi_line;
  logic [7:0] rdata_r, vec_base_r, cascade_map_r, mask_r;
  logic edge_trig_r, cascade_mode_r, auto_eoi_r, eoi_stb_r, eoi_specific_r;
  logic [2:0] eoi_line_r;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pic_cmd_decoder #(.NUM_LINES(8), .IS_MASTER(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .req_in(req_in), .isr_in(isr_in), .edge_trig(edge_trig),
    .cascade_mode(cascade_mode), .vec_base(vec_base), .cascade_map(cascade_map),
    .auto_eoi(auto_eoi), .mask(mask), .eoi_stb(eoi_stb), .eoi_line(eoi_line),
    .eoi_specific(eoi_specific)
  );

  pic_cmd_decoder #(.NUM_LINES(8), .IS_MASTER(1'b0)) uut_r (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_r), .req_in(req_in), .isr_in(isr_in), .edge_trig(edge_trig_r),
    .cascade_mode(cascade_mode_r), .vec_base(vec_base_r),
    .cascade_map(cascade_map_r), .auto_eoi(auto_eoi_r), .mask(mask_r),
    .eoi_stb(eoi_stb_r), .eoi_line(eoi_line_r), .eoi_specific(eoi_specific_r)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Write applied after a falling edge; returns at the falling edge after capture
  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
    addr = 1'b0;
  endtask

  function automatic int top_bit(input logic [7:0] v);
    int r = -1;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R11: reset state and readback
    rd(1'b1, v); chk(v == 8'h00, "R1 mask", v, 0);
    rd(1'b0, v); chk(v == req_in, "R1 R11 readback request", v, req_in);
    chk(auto_eoi == 1'b0, "R1 auto_eoi", auto_eoi, 0);
    wr(1'b1, 8'h5A);
    rd(1'b1, v); chk(v == 8'h5A, "R1 R6 idle mask load", v, 8'h5A);

    // R2 / R3: single mode, sweep every second-word byte
    for (int n = 0; n < 256; n++) begin
      logic [7:0] b;
      b = 8'(n);
      wr(1'b0, 8'h12 | (b[0] ? 8'h08 : 8'h00));
      chk(mask == 8'h00, "R2 init clears mask", mask, 0);
      chk(edge_trig == b[0], "R2 trigger mode", edge_trig, b[0]);
      chk(cascade_mode == 1'b0, "R2 single mode", cascade_mode, 0);
      wr(1'b1, b);
      chk(vec_base == (b & 8'hF8), "R3 vector base", vec_base, b & 8'hF8);
      chk(cascade_map == 8'h00, "R3 map cleared", cascade_map, 0);
      wr(1'b1, ~b);
      chk(mask == ~b, "R3 R6 back to idle", mask, ~b);
    end

    // R4 / R5: cascade with fourth word, sweep every third/fourth byte
    for (int n = 0; n < 256; n++) begin
      logic [7:0] b;
      b = 8'(n);
      wr(1'b0, 8'h11);
      chk(cascade_mode == 1'b1, "R2 cascade mode", cascade_mode, 1);
      wr(1'b1, 8'h20);
      wr(1'b1, b);
      chk(cascade_map == b, "R4 master map", cascade_map, b);
      chk(cascade_map_r == (b & 8'h07), "R4 responder id", cascade_map_r, b & 8'h07);
      chk(mask == 8'h00, "R4 third word not mask", mask, 0);
      wr(1'b1, b);
      chk(auto_eoi == b[1], "R5 auto_eoi", auto_eoi, b[1]);
      chk(mask == 8'h00, "R5 fourth word not mask", mask, 0);
      wr(1'b1, 8'hC3);
      chk(mask == 8'hC3, "R5 R6 idle after fourth", mask, 8'hC3);
    end

    // R2: auto-EOI kept when fourth word requested, cleared otherwise
    wr(1'b0, 8'h11); wr(1'b1, 8'h00); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
    chk(auto_eoi == 1'b1, "R5 auto_eoi set", auto_eoi, 1);
    wr(1'b0, 8'h11);
    chk(auto_eoi == 1'b1, "R2 auto_eoi kept", auto_eoi, 1);
    wr(1'b0, 8'h10);
    chk(auto_eoi == 1'b0, "R2 auto_eoi cleared", auto_eoi, 0);
    // R4: cascade without fourth word goes idle after third
    wr(1'b1, 8'h40); wr(1'b1, 8'h81);
    chk(cascade_map == 8'h81, "R4 map no w4", cascade_map, 8'h81);
    wr(1'b1, 8'h66);
    chk(mask == 8'h66, "R4 idle without w4", mask, 8'h66);
    // R3: single mode skips fourth word even if requested
    wr(1'b0, 8'h13); wr(1'b1, 8'h08); wr(1'b1, 8'h99);
    chk(mask == 8'h99, "R3 single skips w4", mask, 8'h99);

    // R7 / R12: non-specific EOI over every in-service pattern
    for (int n = 0; n < 256; n++) begin
      int t;
      isr_in = 8'(n);
      t = top_bit(isr_in);
      wr(1'b0, 8'h20);
      chk(eoi_stb == (n != 0), "R7 strobe", eoi_stb, n != 0);
      if (n != 0) begin
        chk(eoi_line == 3'(t), "R7 top line", eoi_line, t);
        chk(eoi_specific == 1'b0, "R7 flag", eoi_specific, 0);
      end
      @(negedge clk);
      chk(eoi_stb == 1'b0, "R12 one cycle", eoi_stb, 0);
    end

    // R8: specific EOI every line
    isr_in = 8'h00;
    for (int l = 0; l < 8; l++) begin
      wr(1'b0, 8'h60 | 8'(l));
      chk(eoi_stb && eoi_specific, "R8 strobe", {eoi_stb, eoi_specific}, 3);
      chk(eoi_line == 3'(l), "R8 line", eoi_line, l);
      @(negedge clk);
      chk(eoi_stb == 1'b0, "R12 one cycle spec", eoi_stb, 0);
    end

    // R9: other subcommands ineffective
    isr_in = 8'h81;
    wr(1'b1, 8'h3C);
    for (int s = 0; s < 8; s++) begin
      if (s == 1 || s == 3) continue;
      wr(1'b0, 8'((s << 5) | 3));
      chk(eoi_stb == 1'b0, "R9 no strobe", eoi_stb, 0);
      rd(1'b1, v); chk(v == 8'h3C, "R9 mask kept", v, 8'h3C);
      rd(1'b0, v); chk(v == req_in, "R9 readback kept", v, req_in);
    end

    // R10 / R11: readback selection
    wr(1'b0, 8'h0A);
    rd(1'b0, v); chk(v == isr_in, "R10 select isr", v, isr_in);
    wr(1'b0, 8'h09);
    rd(1'b0, v); chk(v == isr_in, "R10 bit1 clear no change", v, isr_in);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk(v == req_in, "R10 select request", v, req_in);
    req_in = 8'h17;
    rd(1'b0, v); chk(v == 8'h17, "R11 live readback", v, 8'h17);
    rd(1'b1, v); chk(v == 8'h3C, "R11 mask readback", v, 8'h3C);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule